// File: doc/BRIEF.md
# Bank-Aware DRAM Command Scheduler

This block takes read and write requests from an upstream source, keeps up to eight of them pending, and turns them into a stream of DRAM commands, one per cycle. Each command is either a row activation or a column read or write. For every bank it tracks whether a row is open, which row it is, and how many cycles remain before that bank may be activated again. From this state it picks, every cycle, the most useful request that can legally go now. The pick is out of order: requests to an open row go ahead of row changes, and a younger request that can issue skips an older one that would collide with a bank still inside its row-cycle window.

The data bus pays a penalty when it changes direction. A write followed by a read needs fifteen idle data cycles, and a read followed by a write needs six. The scheduler keeps same-direction traffic together while a turnaround is pending. A request that younger ones have overtaken sixteen times takes absolute priority, so no request can wait forever.

Both edges use valid/ready. Requests enter on a cycle with `req_valid` and `req_ready` both high. `req_ready` is low exactly when the queue is full. A command is taken on a cycle with `cmd_valid` and `cmd_ready` both high. While `cmd_valid` is high and `cmd_ready` is low, the offered command does not change. A request leaves the queue only when its column command is taken. An accepted activation leaves the request queued, and it becomes a page hit.

Top module: `dram_sched`

## Requirements
- R1: A read or write command is offered only for a bank whose open row equals the request's row. A request to a closed bank or to another row first receives an activate command (cmd_op 2'b01) for its own bank and row.
- R2: Two activations of the same bank are at least T_RC (default 10) cycles apart. A row change that waits only on this window issues exactly T_RC cycles after the previous activation of that bank.
- R3: Queued page hits go before row changes. A bank's row is not changed while any queued request hits that bank's open row.
- R4: A request whose bank is still inside its T_RC window does not block a younger request to another bank, which is issued first.
- R5: A read is taken at least 16 cycles after the last write, which leaves 15 idle cycles. While reads are held back, hit writes still issue.
- R6: A write is taken at least 7 cycles after the last read, which leaves 6 idle cycles.
- R7: Among requests of equal class, the oldest is chosen.
- R8: A request overtaken by 16 column commands of younger requests is served next: its activation if needed, then its column command.
- R9: cmd_op encodes 2'b00 none, 2'b01 activate, 2'b10 read, 2'b11 write. While cmd_valid is high and cmd_ready is low, cmd_valid, cmd_op, cmd_bank, cmd_row and cmd_col hold their values.
- R10: req_ready is low while 8 requests are queued.
- R11: After reset, no bank is open, the queue is empty, cmd_valid is low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Queue can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | $clog2(NUM_BANKS) | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Command interface accepts |
| cmd_op | output | 2 | Command kind (see R9) |
| cmd_bank | output | $clog2(NUM_BANKS) | Command bank |
| cmd_row | output | ROW_W | Row of the request served |
| cmd_col | output | COL_W | Column of the request served |

## Verification
The bench checks that a row change waits exactly the T_RC window. A design that counts one cycle short would activate early, and one that blocks on the oldest request would stall a free bank. In a write, read, write mix with the hits in one open row, the read must wait 16 cycles while the second write goes first; a design that turns the bus around too soon, or serialises in arrival order, would show a different order or gap. A row change is held off behind a long stream of hits until the sixteenth bypass. A design with no aging would never open the new row, and an off-by-one counter would move the activation by one position. Stability under back-pressure and the full-queue ready are checked as well.

// File: rtl/dsch_pkg.sv
package dsch_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_ACT  = 2'b01,
    OP_RD   = 2'b10,
    OP_WR   = 2'b11
  } dsch_op_e;
endpackage

// File: rtl/dsch_queue.sv
module dsch_queue #(
  parameter int DEPTH  = 8,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 8,
  parameter int COL_W  = 6,
  parameter int STARVE = 16,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int SKIP_W = $clog2(STARVE + 1)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           push_i,
  input  logic                           push_wr_i,
  input  logic [BANK_W-1:0]              push_bank_i,
  input  logic [ROW_W-1:0]               push_row_i,
  input  logic [COL_W-1:0]               push_col_i,
  input  logic                           pop_i,
  input  logic [IDX_W-1:0]               pop_idx_i,
  output logic                           full_o,
  output logic [DEPTH-1:0]               vld_o,
  output logic [DEPTH-1:0]               wr_o,
  output logic [DEPTH-1:0][BANK_W-1:0]   bank_o,
  output logic [DEPTH-1:0][ROW_W-1:0]    row_o,
  output logic [DEPTH-1:0][COL_W-1:0]    col_o,
  output logic [DEPTH-1:0]               starved_o
);
  // Slot 0 is always the oldest entry; removal compacts younger ones down.
  logic [CNT_W-1:0]                cnt_q, cnt_n;
  logic [DEPTH-1:0]                wr_q, wr_n;
  logic [DEPTH-1:0][BANK_W-1:0]    bank_q, bank_n;
  logic [DEPTH-1:0][ROW_W-1:0]     row_q, row_n;
  logic [DEPTH-1:0][COL_W-1:0]     col_q, col_n;
  logic [DEPTH-1:0][SKIP_W-1:0]    skip_q, skip_n;

  always_comb begin
    cnt_n  = cnt_q;
    wr_n   = wr_q;
    bank_n = bank_q;
    row_n  = row_q;
    col_n  = col_q;
    skip_n = skip_q;
    if (pop_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (i >= int'(pop_idx_i)) begin
          if (i < DEPTH - 1) begin
            wr_n[i]   = wr_q[(i + 1) % DEPTH];
            bank_n[i] = bank_q[(i + 1) % DEPTH];
            row_n[i]  = row_q[(i + 1) % DEPTH];
            col_n[i]  = col_q[(i + 1) % DEPTH];
            skip_n[i] = skip_q[(i + 1) % DEPTH];
          end else begin
            wr_n[i]   = 1'b0;
            bank_n[i] = '0;
            row_n[i]  = '0;
            col_n[i]  = '0;
            skip_n[i] = '0;
          end
        end else if (i < int'(cnt_q) && skip_q[i] != SKIP_W'(STARVE)) begin
          // older entry overtaken by a younger column command
          skip_n[i] = skip_q[i] + 1'b1;
        end
      end
      cnt_n = cnt_q - 1'b1;
    end
    if (push_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (i == int'(cnt_n)) begin
          wr_n[i]   = push_wr_i;
          bank_n[i] = push_bank_i;
          row_n[i]  = push_row_i;
          col_n[i]  = push_col_i;
          skip_n[i] = '0;
        end
      end
      cnt_n = cnt_n + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wr_q   <= '0;
      bank_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
      skip_q <= '0;
    end else begin
      cnt_q  <= cnt_n;
      wr_q   <= wr_n;
      bank_q <= bank_n;
      row_q  <= row_n;
      col_q  <= col_n;
      skip_q <= skip_n;
    end
  end

  assign full_o = (cnt_q == CNT_W'(DEPTH));
  assign wr_o   = wr_q;
  assign bank_o = bank_q;
  assign row_o  = row_q;
  assign col_o  = col_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign vld_o[g]     = (g < int'(cnt_q));
    assign starved_o[g] = vld_o[g] && (skip_q[g] == SKIP_W'(STARVE));

    // R8
    skip_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      skip_q[g] <= SKIP_W'(STARVE));
  end

  // R10
  depth_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  // R10
  push_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_o && !pop_i |=> full_o);
endmodule

// File: rtl/dsch_banks.sv
module dsch_banks #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 8,
  parameter int T_RC      = 10,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int TC_W   = $clog2(T_RC + 1)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             act_i,
  input  logic [BANK_W-1:0]                act_bank_i,
  input  logic [ROW_W-1:0]                 act_row_i,
  output logic [NUM_BANKS-1:0]             open_o,
  output logic [NUM_BANKS-1:0][ROW_W-1:0]  row_o,
  output logic [NUM_BANKS-1:0]             trc_zero_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic             open_q;
    logic [ROW_W-1:0] row_q;
    logic [TC_W-1:0]  tc_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_q <= 1'b0;
        row_q  <= '0;
        tc_q   <= '0;
      end else if (act_i && act_bank_i == BANK_W'(b)) begin
        open_q <= 1'b1;
        row_q  <= act_row_i;
        tc_q   <= TC_W'(T_RC - 1);
      end else if (tc_q != '0) begin
        tc_q <= tc_q - 1'b1;
      end
    end

    assign open_o[b]     = open_q;
    assign row_o[b]      = row_q;
    assign trc_zero_o[b] = (tc_q == '0);
  end

  // R2
  act_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_i |-> trc_zero_o[act_bank_i]);
endmodule

// File: rtl/dsch_pick.sv
module dsch_pick
  import dsch_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 8,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]                 vld_i,
  input  logic [DEPTH-1:0]                 wr_i,
  input  logic [DEPTH-1:0][BANK_W-1:0]     bank_i,
  input  logic [DEPTH-1:0][ROW_W-1:0]      row_i,
  input  logic [DEPTH-1:0]                 starved_i,
  input  logic [NUM_BANKS-1:0]             open_i,
  input  logic [NUM_BANKS-1:0][ROW_W-1:0]  open_row_i,
  input  logic [NUM_BANKS-1:0]             trc_zero_i,
  input  logic                             rd_ok_i,
  input  logic                             wr_ok_i,
  output logic                             pick_vld_o,
  output logic [IDX_W-1:0]                 pick_idx_o,
  output dsch_op_e                         pick_op_o
);
  logic [DEPTH-1:0]     hit, col_ok, row_free, act_ok;
  logic [NUM_BANKS-1:0] hit_pend;

  for (genvar g = 0; g < DEPTH; g++) begin : g_class
    assign hit[g]      = vld_i[g] && open_i[bank_i[g]] &&
                         (open_row_i[bank_i[g]] == row_i[g]);
    assign col_ok[g]   = hit[g] && (wr_i[g] ? wr_ok_i : rd_ok_i);
    assign row_free[g] = vld_i[g] && !hit[g] && trc_zero_i[bank_i[g]];
    assign act_ok[g]   = row_free[g] && !hit_pend[bank_i[g]];
  end

  always_comb begin
    hit_pend = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (hit[i]) hit_pend[bank_i[i]] = 1'b1;
    end
  end

  logic             any_st, any_col, any_act;
  logic [IDX_W-1:0] st_idx, col_idx, act_idx;

  // Scan from the youngest slot down so the oldest match is kept.
  always_comb begin
    any_st  = 1'b0; st_idx  = '0;
    any_col = 1'b0; col_idx = '0;
    any_act = 1'b0; act_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (starved_i[i]) begin any_st = 1'b1; st_idx = IDX_W'(i); end
      if (col_ok[i])    begin any_col = 1'b1; col_idx = IDX_W'(i); end
      if (act_ok[i])    begin any_act = 1'b1; act_idx = IDX_W'(i); end
    end
  end

  always_comb begin
    pick_vld_o = 1'b0;
    pick_idx_o = '0;
    pick_op_o  = OP_NONE;
    if (any_st) begin
      pick_idx_o = st_idx;
      if (col_ok[st_idx]) begin
        pick_vld_o = 1'b1;
        pick_op_o  = wr_i[st_idx] ? OP_WR : OP_RD;
      end else if (row_free[st_idx]) begin
        pick_vld_o = 1'b1;
        pick_op_o  = OP_ACT;
      end
    end else if (any_col) begin
      pick_vld_o = 1'b1;
      pick_idx_o = col_idx;
      pick_op_o  = wr_i[col_idx] ? OP_WR : OP_RD;
    end else if (any_act) begin
      pick_vld_o = 1'b1;
      pick_idx_o = act_idx;
      pick_op_o  = OP_ACT;
    end
  end
endmodule

// File: rtl/dram_sched.sv
module dram_sched
  import dsch_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int QDEPTH     = 8,
  parameter int ROW_W      = 8,
  parameter int COL_W      = 6,
  parameter int T_RC       = 10,
  parameter int T_RD2WR    = 6,
  parameter int T_WR2RD    = 15,
  parameter int STARVE_LIM = 16,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int IDX_W  = $clog2(QDEPTH),
  localparam int TA_MAX = (T_RD2WR > T_WR2RD) ? T_RD2WR : T_WR2RD,
  localparam int TA_W   = $clog2(TA_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [COL_W-1:0]  cmd_col
);
  logic                             q_full;
  logic [QDEPTH-1:0]                q_vld, q_wr, q_starved;
  logic [QDEPTH-1:0][BANK_W-1:0]    q_bank;
  logic [QDEPTH-1:0][ROW_W-1:0]     q_row;
  logic [QDEPTH-1:0][COL_W-1:0]     q_col;
  logic [NUM_BANKS-1:0]             b_open, b_trc_zero;
  logic [NUM_BANKS-1:0][ROW_W-1:0]  b_row;
  logic                             pick_vld;
  logic [IDX_W-1:0]                 pick_idx;
  dsch_op_e                         pick_op;

  logic             hold_q;
  logic [IDX_W-1:0] hold_idx_q;
  dsch_op_e         hold_op_q;
  logic             sel_vld;
  logic [IDX_W-1:0] sel_idx;
  dsch_op_e         sel_op;
  logic             fire, act_fire, col_fire, push;
  logic [TA_W-1:0]  rd_wait_q, wr_wait_q;

  assign req_ready = !q_full;
  assign push      = req_valid && !q_full;

  // A command left waiting is frozen until taken.
  assign sel_vld  = hold_q || pick_vld;
  assign sel_idx  = hold_q ? hold_idx_q : pick_idx;
  assign sel_op   = hold_q ? hold_op_q  : pick_op;
  assign fire     = sel_vld && cmd_ready;
  assign act_fire = fire && (sel_op == OP_ACT);
  assign col_fire = fire && (sel_op == OP_RD || sel_op == OP_WR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q     <= 1'b0;
      hold_idx_q <= '0;
      hold_op_q  <= OP_NONE;
    end else begin
      hold_q     <= sel_vld && !cmd_ready;
      hold_idx_q <= sel_idx;
      hold_op_q  <= sel_op;
    end
  end

  // Bus turnaround: each direction blocked for a while after the other one.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_wait_q <= '0;
      wr_wait_q <= '0;
    end else begin
      if (col_fire && sel_op == OP_WR) rd_wait_q <= TA_W'(T_WR2RD);
      else if (rd_wait_q != '0)        rd_wait_q <= rd_wait_q - 1'b1;
      if (col_fire && sel_op == OP_RD) wr_wait_q <= TA_W'(T_RD2WR);
      else if (wr_wait_q != '0)        wr_wait_q <= wr_wait_q - 1'b1;
    end
  end

  dsch_queue #(
    .DEPTH(QDEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .STARVE(STARVE_LIM)
  ) queue_i (
    .clk(clk), .rst_n(rst_n),
    .push_i(push), .push_wr_i(req_write), .push_bank_i(req_bank),
    .push_row_i(req_row), .push_col_i(req_col),
    .pop_i(col_fire), .pop_idx_i(sel_idx),
    .full_o(q_full), .vld_o(q_vld), .wr_o(q_wr), .bank_o(q_bank),
    .row_o(q_row), .col_o(q_col), .starved_o(q_starved)
  );

  dsch_banks #(
    .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .T_RC(T_RC)
  ) banks_i (
    .clk(clk), .rst_n(rst_n),
    .act_i(act_fire), .act_bank_i(q_bank[sel_idx]), .act_row_i(q_row[sel_idx]),
    .open_o(b_open), .row_o(b_row), .trc_zero_o(b_trc_zero)
  );

  dsch_pick #(
    .DEPTH(QDEPTH), .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)
  ) pick_i (
    .vld_i(q_vld), .wr_i(q_wr), .bank_i(q_bank), .row_i(q_row),
    .starved_i(q_starved), .open_i(b_open), .open_row_i(b_row),
    .trc_zero_i(b_trc_zero),
    .rd_ok_i(rd_wait_q == '0), .wr_ok_i(wr_wait_q == '0),
    .pick_vld_o(pick_vld), .pick_idx_o(pick_idx), .pick_op_o(pick_op)
  );

  assign cmd_valid = sel_vld;
  assign cmd_op    = sel_vld ? sel_op : OP_NONE;
  assign cmd_bank  = q_bank[sel_idx];
  assign cmd_row   = q_row[sel_idx];
  assign cmd_col   = q_col[sel_idx];

  // Independent gap counters for the turnaround checks.
  localparam int GAP_W = $clog2(TA_MAX + 2);
  logic [GAP_W-1:0] since_wr_q, since_rd_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_wr_q <= GAP_W'(TA_MAX + 1);
      since_rd_q <= GAP_W'(TA_MAX + 1);
    end else begin
      if (cmd_valid && cmd_ready && cmd_op == 2'b11) since_wr_q <= '0;
      else if (since_wr_q != GAP_W'(TA_MAX + 1))     since_wr_q <= since_wr_q + 1'b1;
      if (cmd_valid && cmd_ready && cmd_op == 2'b10) since_rd_q <= '0;
      else if (since_rd_q != GAP_W'(TA_MAX + 1))     since_rd_q <= since_rd_q + 1'b1;
    end
  end

  // R5
  wr_to_rd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_op == 2'b10 |-> since_wr_q >= GAP_W'(T_WR2RD));

  // R6
  rd_to_wr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_op == 2'b11 |-> since_rd_q >= GAP_W'(T_RD2WR));

  // R9
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_bank)
                                && $stable(cmd_row) && $stable(cmd_col));

  // R1
  col_open_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op[1] |-> b_open[cmd_bank] && b_row[cmd_bank] == cmd_row);
endmodule

// File: tb/dram_sched_tb.sv
module dram_sched_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_write = 1'b0;
  logic       req_ready;
  logic [1:0] req_bank = '0;
  logic [7:0] req_row = '0;
  logic [5:0] req_col = '0;
  logic       cmd_valid, cmd_ready = 1'b0;
  logic [1:0] cmd_op, cmd_bank;
  logic [7:0] cmd_row;
  logic [5:0] cmd_col;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dram_sched dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col)
  );

  localparam logic [1:0] ACT = 2'b01, RD = 2'b10, WR = 2'b11;

  int total = 0, bad = 0, cyc = 0;
  bit done = 1'b0;
  logic [17:0] sb_q[$];
  string       sb_tag[$];
  int          issue_cyc[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_cmd(input logic [1:0] op, input logic [1:0] b,
                            input logic [7:0] r, input logic [5:0] c, input string tag);
    sb_q.push_back({op, b, r, (op == ACT) ? 6'd0 : c});
    sb_tag.push_back(tag);
  endtask

  // Monitor: compare every accepted command with the scoreboard head.
  always @(negedge clk) begin
    cyc++;
    if (rst_n && cmd_valid && cmd_ready) begin
      logic [17:0] got;
      got = {cmd_op, cmd_bank, cmd_row, (cmd_op == ACT) ? 6'd0 : cmd_col};
      issue_cyc.push_back(cyc);
      if (sb_q.size() == 0) chk(1'b0, "unexpected command", int'(got), -1);
      else begin
        logic [17:0] e;
        string t;
        e = sb_q.pop_front();
        t = sb_tag.pop_front();
        chk(got == e, t, int'(got), int'(e));
      end
    end
  end

  task automatic push(input bit w, input logic [1:0] b, input logic [7:0] r, input logic [5:0] c);
    req_valid = 1'b1; req_write = w; req_bank = b; req_row = r; req_col = c;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while (sb_q.size() != 0 && n < 2000) begin @(posedge clk); n++; end
    repeat (40) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int base;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R11: idle after reset
    chk(cmd_valid == 1'b0, "R11 cmd_valid after reset", cmd_valid, 0);
    chk(req_ready == 1'b1, "R11 req_ready after reset", req_ready, 1);
    @(posedge clk); #1;

    // Test A: R1 activation first, R3/R7 hits oldest-first, R2 exact window, R9 hold
    base = issue_cyc.size();
    expect_cmd(ACT, 0, 5, 0, "R1 activate closed bank");
    expect_cmd(RD, 0, 5, 1, "R7 oldest hit first");
    expect_cmd(RD, 0, 5, 3, "R3 hit before row change");
    expect_cmd(ACT, 0, 7, 0, "R2 row change after window");
    expect_cmd(RD, 0, 7, 2, "R1 read after its activation");
    push(0, 0, 5, 1);
    push(0, 0, 7, 2);
    push(0, 0, 5, 3);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      // R9: held command unchanged under back-pressure
      chk(cmd_valid && cmd_op == ACT && cmd_bank == 0 && cmd_row == 5,
          "R9 held command", {cmd_op, cmd_bank, cmd_row}, {ACT, 2'd0, 8'd5});
    end
    @(posedge clk); #1 cmd_ready = 1'b1;
    drain();
    chk(issue_cyc[base+3] - issue_cyc[base] == 10, "R2 activate spacing",
        issue_cyc[base+3] - issue_cyc[base], 10);

    // Test B: R4 conflicting request skipped for another bank
    base = issue_cyc.size();
    cmd_ready = 1'b0;
    expect_cmd(ACT, 1, 1, 0, "R4 first activate");
    expect_cmd(RD, 1, 1, 0, "R4 hit read");
    expect_cmd(ACT, 2, 3, 0, "R4 younger bank goes first");
    expect_cmd(RD, 2, 3, 0, "R4 younger read");
    expect_cmd(ACT, 1, 2, 0, "R4 conflict served later");
    expect_cmd(RD, 1, 2, 0, "R4 conflict read");
    push(0, 1, 1, 0);
    push(0, 1, 2, 0);
    push(0, 2, 3, 0);
    cmd_ready = 1'b1;
    drain();
    chk(issue_cyc[base+4] - issue_cyc[base] == 10, "R2 bank1 spacing",
        issue_cyc[base+4] - issue_cyc[base], 10);

    // Test C: R5 write-to-read turnaround, second write overtakes the read
    base = issue_cyc.size();
    cmd_ready = 1'b0;
    expect_cmd(WR, 2, 3, 4, "R5 first write");
    expect_cmd(WR, 2, 3, 6, "R5 write passes held read");
    expect_cmd(RD, 2, 3, 5, "R5 read after turnaround");
    push(1, 2, 3, 4);
    push(0, 2, 3, 5);
    push(1, 2, 3, 6);
    cmd_ready = 1'b1;
    drain();
    chk(issue_cyc[base+2] - issue_cyc[base+1] == 16, "R5 write-to-read gap",
        issue_cyc[base+2] - issue_cyc[base+1], 16);

    // Test D: R6 read-to-write turnaround
    base = issue_cyc.size();
    cmd_ready = 1'b0;
    expect_cmd(RD, 2, 3, 1, "R6 read");
    expect_cmd(WR, 2, 3, 2, "R6 write");
    push(0, 2, 3, 1);
    push(1, 2, 3, 2);
    cmd_ready = 1'b1;
    drain();
    chk(issue_cyc[base+1] - issue_cyc[base] == 7, "R6 read-to-write gap",
        issue_cyc[base+1] - issue_cyc[base], 7);

    // Test E: R8 aging against a stream of hits, R10 full queue
    cmd_ready = 1'b0;
    for (int i = 0; i <= 16; i++) expect_cmd(RD, 0, 7, 6'(i), "R8 hit stream");
    expect_cmd(ACT, 0, 9, 0, "R8 starved request activates");
    expect_cmd(RD, 0, 9, 40, "R8 starved request reads");
    expect_cmd(ACT, 0, 7, 0, "R8 later hit reopens row");
    expect_cmd(RD, 0, 7, 17, "R8 last read");
    push(0, 0, 7, 0);
    push(0, 0, 9, 40);
    for (int i = 1; i <= 6; i++) push(0, 0, 7, 6'(i));
    @(negedge clk);
    // R10
    chk(req_ready == 1'b0, "R10 ready low when full", req_ready, 0);
    @(posedge clk); #1 cmd_ready = 1'b1;
    for (int i = 7; i <= 17; i++) push(0, 0, 7, 6'(i));
    drain();
    chk(sb_q.size() == 0, "R8 all commands seen", sb_q.size(), 0);

    finish_run();
  end
endmodule